// File: doc/BRIEF.md
# Hierarchical First/Next Error Logger

This block gathers error events from several functional units and records them in two levels of first-error and next-error registers. Each unit has a pair of registers. The first-error register holds the error or errors that opened an episode. The next-error register collects every error that arrives after that. Above the units sits a global pair with one bit per unit, and it records which units reported errors.

Each unit also has three enable masks. Each mask routes that unit's logged error bits onto one of three level outputs: system error, system control interrupt and system management interrupt. The system error output is meant for catastrophic conditions such as address or data parity failures. One error can raise any combination of the three outputs. Software reads the registers through a simple register port and retires logged bits by writing ones to them.

Top module: `err_hier_logger`

## Requirements
- R1: When a unit's first-error register is all-zero, every error bit that arrives in one cycle is latched into it, and bits that arrive together are ORed.
- R2: While a unit's first-error register is non-zero, new error bits leave it unchanged and instead set the matching bits of the unit's next-error register.
- R3: Writing to a first-error or next-error register clears each bit written as one. Bits written as zero are unaffected. Register select is addr[2:0], with 0 selecting first, 1 selecting next, 2 the system-error enable, 3 the control-interrupt enable and 4 the management-interrupt enable. The unit index is addr[ADDR_W-1:3].
- R4: If an error bit is set in the same cycle that a write clears it, the bit stays set.
- R5: Global bit u is set whenever any error input of unit u is high. The global pair follows the same first/next rules as the unit pairs. It sits at unit index NUM_UNITS, with select 0 for first and 1 for next, and it is cleared by writing ones.
- R6: The enable registers are plain read/write and read back the last value written.
- R7: Each output is the OR over all units of (first | next) AND that output's enable mask. Several outputs may be high at once for the same error.
- R8: An output stays high until the logged bits behind it are cleared, and it falls in the cycle after the clearing write.
- R9: After reset, all registers read zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| err_i | input | NUM_UNITS*ERR_W | Error event bits; unit u uses slice [u*ERR_W +: ERR_W] |
| reg_addr | input | ADDR_W | Register address: unit index above, register select in [2:0] |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | ERR_W | Write data (clear mask or enable value) |
| reg_rdata | output | ERR_W | Read data for reg_addr, combinational; unmapped reads return zero |
| sys_err_o | output | 1 | System error level output |
| ctl_irq_o | output | 1 | System control interrupt level output |
| mgt_irq_o | output | 1 | System management interrupt level output |

## Verification
The bench targets the boundary between first and next capture. It clears the first-error register in the same cycle that a new error arrives, and it raises errors in two units in one cycle. A design that tested the cleared value would misfile the error into first, and one that kept only the lowest unit would lose a global bit. It writes a clear to a bit that is being set in that same cycle, where a clear-wins design would drop the error. It also enables two outputs on one error bit to catch routing that is exclusive or that stays stuck after the bits are cleared.

// File: rtl/elog_pkg.sv
package elog_pkg;

  // register select field, addr[2:0]
  typedef enum logic [2:0] {
    SEL_FIRST  = 3'd0,
    SEL_NEXT   = 3'd1,
    SEL_EN_SYS = 3'd2,
    SEL_EN_CTL = 3'd3,
    SEL_EN_MGT = 3'd4
  } reg_sel_e;

  localparam int NUM_MSG = 3;
  localparam int MSG_SYS = 0;
  localparam int MSG_CTL = 1;
  localparam int MSG_MGT = 2;
  localparam int SEL_W   = 3;

endpackage

// File: rtl/elog_rst_sync.sv
module elog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/elog_capture.sv
module elog_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_first_i,
  input  logic [W-1:0] clr_next_i,
  output logic [W-1:0] first_o,
  output logic [W-1:0] next_o
);

  logic [W-1:0] first_q, first_d;
  logic [W-1:0] next_q,  next_d;
  logic         upd_en;

  // set beats clear: the clear mask is applied first, the new events ORed after
  always_comb begin
    first_d = first_q & ~clr_first_i;
    next_d  = next_q  & ~clr_next_i;
    if (first_q == '0) first_d = first_d | ev_i;
    else               next_d  = next_d  | ev_i;
  end

  assign upd_en = (|ev_i) | (|clr_first_i) | (|clr_next_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else if (upd_en) begin
      first_q <= first_d;
      next_q  <= next_d;
    end
  end

  assign first_o = first_q;
  assign next_o  = next_q;

  // R1: an empty first register takes the whole event vector
  p_first_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q == '0 && ev_i != '0) |=> (first_q == $past(ev_i)));

  // R2: a non-empty first register is not disturbed by events
  p_first_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != '0 && clr_first_i == '0) |=> (first_q == $past(first_q)));

  // R2: events seen while first is occupied land in next
  p_next_collect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != '0) |=> ((next_q & $past(ev_i)) == $past(ev_i)));

  // R4: an event is never lost to a same-cycle clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> (((first_q | next_q) & $past(ev_i)) == $past(ev_i)));

endmodule

// File: rtl/elog_unit.sv
module elog_unit
  import elog_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_i,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [ERR_W-1:0] wdata_i,
  output logic [ERR_W-1:0] first_o,
  output logic [ERR_W-1:0] next_o,
  output logic [ERR_W-1:0] en_o [NUM_MSG],
  output logic [NUM_MSG-1:0] msg_o
);

  logic [ERR_W-1:0] clr_first, clr_next;
  logic [ERR_W-1:0] logged;

  always_comb begin
    clr_first = (wr_i && sel_i == SEL_FIRST) ? wdata_i : '0;
    clr_next  = (wr_i && sel_i == SEL_NEXT)  ? wdata_i : '0;
  end

  elog_capture #(.W(ERR_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (err_i),
    .clr_first_i (clr_first),
    .clr_next_i  (clr_next),
    .first_o     (first_o),
    .next_o      (next_o)
  );

  assign logged = first_o | next_o;

  for (genvar m = 0; m < NUM_MSG; m++) begin : g_msg
    localparam reg_sel_e MY_SEL = reg_sel_e'(SEL_EN_SYS + m);
    logic [ERR_W-1:0] en_q, en_d;
    logic             en_we;

    assign en_we = wr_i && (sel_i == MY_SEL);

    always_comb begin
      en_d = en_q;
      if (en_we) en_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_d;
    end

    assign en_o[m]  = en_q;
    assign msg_o[m] = |(logged & en_q);
  end

endmodule

// File: rtl/err_hier_logger.sv
module err_hier_logger
  import elog_pkg::*;
#(
  parameter  int NUM_UNITS = 4,
  parameter  int ERR_W     = 8,
  localparam int UIDX_W    = $clog2(NUM_UNITS + 1),
  localparam int ADDR_W    = UIDX_W + SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_UNITS*ERR_W-1:0] err_i,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_wr,
  input  logic [ERR_W-1:0]           reg_wdata,
  output logic [ERR_W-1:0]           reg_rdata,
  output logic                       sys_err_o,
  output logic                       ctl_irq_o,
  output logic                       mgt_irq_o
);

  localparam logic [UIDX_W-1:0] GLOBAL_IDX = UIDX_W'(NUM_UNITS);

  logic                 rst_n_s;
  logic [UIDX_W-1:0]    addr_unit;
  reg_sel_e             addr_sel;

  logic [ERR_W-1:0]     u_first [NUM_UNITS];
  logic [ERR_W-1:0]     u_next  [NUM_UNITS];
  logic [ERR_W-1:0]     u_en    [NUM_UNITS][NUM_MSG];
  logic [NUM_MSG-1:0]   u_msg   [NUM_UNITS];

  logic [NUM_UNITS-1:0] unit_ev;
  logic [NUM_UNITS-1:0] g_first, g_next;
  logic [NUM_UNITS-1:0] g_clr_first, g_clr_next;
  logic                 g_hit;
  logic [NUM_MSG-1:0]   msg_any;

  elog_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  assign addr_unit = reg_addr[ADDR_W-1:SEL_W];
  assign addr_sel  = reg_sel_e'(reg_addr[SEL_W-1:0]);

  // per-unit register pairs and routing masks
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic hit;
    assign hit        = (addr_unit == UIDX_W'(u));
    assign unit_ev[u] = |err_i[u*ERR_W +: ERR_W];

    elog_unit #(.ERR_W(ERR_W)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .err_i   (err_i[u*ERR_W +: ERR_W]),
      .wr_i    (reg_wr && hit),
      .sel_i   (addr_sel),
      .wdata_i (reg_wdata),
      .first_o (u_first[u]),
      .next_o  (u_next[u]),
      .en_o    (u_en[u]),
      .msg_o   (u_msg[u])
    );

    // R5: any event of this unit shows up in the global pair
    p_global_track_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
      unit_ev[u] |=> (g_first[u] | g_next[u]));
  end

  // global pair: one bit per reporting unit
  assign g_hit = (addr_unit == GLOBAL_IDX);

  always_comb begin
    g_clr_first = '0;
    g_clr_next  = '0;
    if (reg_wr && g_hit && addr_sel == SEL_FIRST) g_clr_first = reg_wdata[NUM_UNITS-1:0];
    if (reg_wr && g_hit && addr_sel == SEL_NEXT)  g_clr_next  = reg_wdata[NUM_UNITS-1:0];
  end

  elog_capture #(.W(NUM_UNITS)) u_global (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ev_i        (unit_ev),
    .clr_first_i (g_clr_first),
    .clr_next_i  (g_clr_next),
    .first_o     (g_first),
    .next_o      (g_next)
  );

  // message outputs: OR across units
  always_comb begin
    msg_any = '0;
    for (int u = 0; u < NUM_UNITS; u++) msg_any = msg_any | u_msg[u];
  end

  assign sys_err_o = msg_any[MSG_SYS];
  assign ctl_irq_o = msg_any[MSG_CTL];
  assign mgt_irq_o = msg_any[MSG_MGT];

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (g_hit) begin
      if (addr_sel == SEL_FIRST) reg_rdata = ERR_W'(g_first);
      if (addr_sel == SEL_NEXT)  reg_rdata = ERR_W'(g_next);
    end
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (addr_unit == UIDX_W'(u)) begin
        case (addr_sel)
          SEL_FIRST:  reg_rdata = u_first[u];
          SEL_NEXT:   reg_rdata = u_next[u];
          SEL_EN_SYS: reg_rdata = u_en[u][MSG_SYS];
          SEL_EN_CTL: reg_rdata = u_en[u][MSG_CTL];
          SEL_EN_MGT: reg_rdata = u_en[u][MSG_MGT];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end

  // R9: while the internal reset is held, nothing is signalled
  p_quiet_in_reset_r9: assert property (@(posedge clk)
    !rst_n_s |-> !(sys_err_o | ctl_irq_o | mgt_irq_o));

endmodule

// File: tb/err_hier_logger_test.sv
module err_hier_logger_test;

  localparam int NU     = 4;
  localparam int EW     = 8;
  localparam int AW     = 6;
  localparam int GIDX   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NU*EW-1:0]  err_i;
  logic [AW-1:0]     reg_addr;
  logic              reg_wr;
  logic [EW-1:0]     reg_wdata;
  logic [EW-1:0]     reg_rdata;
  logic              sys_err_o, ctl_irq_o, mgt_irq_o;

  int checks = 0;
  int errors = 0;

  err_hier_logger #(.NUM_UNITS(NU), .ERR_W(EW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_i     (err_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sys_err_o (sys_err_o),
    .ctl_irq_o (ctl_irq_o),
    .mgt_irq_o (mgt_irq_o)
  );

  always #4 clk = ~clk;

  // vector: {clear-next select, unit, error bits, clear mask, expected first, expected next}
  localparam int VN = 9;
  localparam logic [34:0] VEC [VN] = '{
    {1'b0, 2'd1, 8'h01, 8'h00, 8'h01, 8'h00},  // R1 empty first latches
    {1'b0, 2'd1, 8'h06, 8'h00, 8'h01, 8'h06},  // R2 follow-on goes to next
    {1'b0, 2'd1, 8'h00, 8'h01, 8'h00, 8'h06},  // R3 clear first only
    {1'b0, 2'd1, 8'h80, 8'h00, 8'h80, 8'h06},  // R1 relatch after clear
    {1'b0, 2'd1, 8'h08, 8'h80, 8'h00, 8'h0E},  // R2 clear+error same cycle: error to next
    {1'b0, 2'd1, 8'h10, 8'h00, 8'h10, 8'h0E},  // R1
    {1'b1, 2'd1, 8'h02, 8'h02, 8'h10, 8'h0E},  // R4 set wins over clear
    {1'b1, 2'd1, 8'h00, 8'hFF, 8'h10, 8'h00},  // R3 clear next
    {1'b0, 2'd1, 8'h00, 8'hFF, 8'h00, 8'h00}   // R3 clear first
  };

  function automatic logic [AW-1:0] adr(input int unit, input int sel);
    return AW'((unit << 3) | sel);
  endfunction

  task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int unit, input int sel, output logic [EW-1:0] v);
    reg_addr = adr(unit, sel);
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input int unit, input int sel, input logic [EW-1:0] d);
    @(negedge clk);
    reg_addr = adr(unit, sel); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse2(input int ua, input logic [EW-1:0] ea, input int ub, input logic [EW-1:0] eb);
    @(negedge clk);
    err_i = '0;
    err_i[ua*EW +: EW] = ea;
    err_i[ub*EW +: EW] = eb;
    @(negedge clk);
    err_i = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [EW-1:0] v;
    rst_n = 1'b0; err_i = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 outputs", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'h00);
    rd(0, 0, v); check("R9 unit0 first", v, 8'h00);
    rd(3, 4, v); check("R9 unit3 mgt enable", v, 8'h00);
    rd(GIDX, 0, v); check("R9 global first", v, 8'h00);

    // table walk on unit 1
    for (int i = 0; i < VN; i++) begin
      logic        csel;
      logic [1:0]  un;
      logic [7:0]  e, c, ef, en;
      {csel, un, e, c, ef, en} = VEC[i];
      @(negedge clk);
      err_i = '0;
      err_i[int'(un)*EW +: EW] = e;
      if (c != 8'h00) begin
        reg_addr = adr(int'(un), csel ? 1 : 0); reg_wdata = c; reg_wr = 1'b1;
      end
      @(negedge clk);
      err_i = '0; reg_wr = 1'b0;
      rd(int'(un), 0, v); check($sformatf("R1/R2/R3/R4 vec%0d first", i), v, ef);
      rd(int'(un), 1, v); check($sformatf("R1/R2/R3/R4 vec%0d next", i), v, en);
    end

    // R5 global recorded unit 1 in first and in next
    rd(GIDX, 0, v); check("R5 global first after unit1", v, 8'h02);
    rd(GIDX, 1, v); check("R5 global next after unit1", v, 8'h02);
    wr(GIDX, 0, 8'hFF);
    wr(GIDX, 1, 8'hFF);
    rd(GIDX, 0, v); check("R5 global first cleared", v, 8'h00);
    rd(GIDX, 1, v); check("R5 global next cleared", v, 8'h00);

    // simultaneous errors in two units
    pulse2(0, 8'h01, 2, 8'h04);
    rd(0, 0, v); check("R1 unit0 first same cycle", v, 8'h01);
    rd(2, 0, v); check("R1 unit2 first same cycle", v, 8'h04);
    rd(GIDX, 0, v); check("R5 global first two units", v, 8'h05);
    rd(GIDX, 1, v); check("R5 global next empty", v, 8'h00);
    check("R7 no enables no output", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'h00);

    pulse2(2, 8'h01, 2, 8'h01);
    rd(2, 1, v); check("R2 unit2 next", v, 8'h01);
    rd(2, 0, v); check("R2 unit2 first held", v, 8'h04);
    rd(GIDX, 1, v); check("R5 global next unit2", v, 8'h04);

    // R6 enable readback and R7 routing
    wr(0, 2, 8'h01);
    wr(0, 3, 8'h01);
    rd(0, 2, v); check("R6 sys enable readback", v, 8'h01);
    rd(0, 3, v); check("R6 ctl enable readback", v, 8'h01);
    check("R7 two outputs one error", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'b110);
    wr(2, 4, 8'h01);
    rd(2, 4, v); check("R6 mgt enable readback", v, 8'h01);
    check("R7 all three outputs", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'b111);
    wr(2, 4, 8'h02);
    check("R7 mask miss drops mgt", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'b110);

    // R8 persistence and drop after clear
    repeat (5) @(negedge clk);
    check("R8 outputs persist", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'b110);
    wr(0, 0, 8'h01);
    check("R8 outputs fall after clear", EW'({sys_err_o, ctl_irq_o, mgt_irq_o}), 8'b000);
    rd(0, 0, v); check("R3 unit0 first cleared", v, 8'h00);

    // R3 zero bits in a clear write have no effect
    wr(2, 0, 8'h00);
    rd(2, 0, v); check("R3 zero write keeps first", v, 8'h04);

    finish_run();
  end

endmodule